// File: doc/BRIEF.md
# Watchdog Timer and Interrupt Flag Controller

This block pairs a slow countdown watchdog with an interrupt merger. The watchdog runs from a 32,768 Hz tick strobe, divided down to 32 steps per second. Software arms it by writing a 6-bit timeout value. When the count reaches zero, the watchdog raises its flag. Two external event sources, a power-fail signal and an alarm-match signal, latch flags of their own on their rising edges. Each of the three flags has its own enable bit. The enabled flags are merged onto a single interrupt pin.

The pin can run in level mode or pulse mode, and its active polarity is selectable. In level mode it holds until the flags are read. In pulse mode it gives a fixed-length pulse for each new enabled event. A read of the flag register returns the flags and clears them, together with the pin. The pin stays quiet while the system is on backup power, and also until the power-up recall has finished. Flags still latch during that time.

Top module: `wic_top`

## Requirements
- R1: After reset the control and load registers are 0 and all flags are clear. With the polarity bit at 0, `irq_out` idles high.
- R2: A write to register 1 loads bits 5:0 as the timeout L. After L×1024 asserted `tick_32k` strobes, flag bit 0 (register 2) sets.
- R3: A timeout value of 0 stops the watchdog, and flag bit 0 never sets.
- R4: Rewriting register 1 restarts the countdown from the new value, discarding the partial count.
- R5: A rising edge on `pf_in` sets flag bit 1, and a rising edge on `alarm_in` sets flag bit 2. A held level sets a flag only once.
- R6: Control register 0 holds three enables: bit 0 for the watchdog, bit 1 for power-fail and bit 2 for alarm. A flag whose enable is 0 does not drive the pin, but it stays readable.
- R7: In level mode (control bit 3 = 0) the pin goes active on the clock edge at which an enabled flag sets. It holds until a flag read clears it.
- R8: In pulse mode (control bit 3 = 1) each new enabled event makes the pin active for exactly PULSE_CYC (default 4) cycles.
- R9: Control bit 4 selects polarity. A value of 1 means active high, and 0 means active low.
- R10: A read of register 2 returns the flags in bits 2:0. At that clock edge it clears all flags and deactivates the pin.
- R11: A flag that sets on the same edge as a flag read stays set, and it drives the pin as a new event.
- R12: While `on_main_power` or `recall_done` is low, the pin stays inactive and flags still latch. In level mode a pending enabled flag activates the pin once both are high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle strobe at 32,768 Hz |
| pf_in | input | 1 | Power-fail event input |
| alarm_in | input | 1 | Alarm-match event input |
| on_main_power | input | 1 | High when the system runs on normal power |
| recall_done | input | 1 | High once the power-up recall has completed |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 timeout, 2 flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq_out | output | 1 | Interrupt pin |

## Verification
The hardest situation to reach is an event that coincides with a flag read while the pin is gated or the mode is changing. A constrained-random phase with a fixed seed toggles the event inputs, reads, control writes and the power gates every cycle. A bench model predicts the pin and the flag reads for each of those cycles. Directed cases cover the exact watchdog expiry cycle, a reload partway through the countdown, the pulse width and the same-edge set-and-read.

// File: rtl/wic_pkg.sv
package wic_pkg;
    localparam int NSRC = 3;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LOAD = 2'd1;
    localparam logic [1:0] ADDR_FLAG = 2'd2;

    typedef struct packed {
        logic pol_high;
        logic pulse;
        logic al_en;
        logic pf_en;
        logic wd_en;
    } ctrl_t;
endpackage

// File: rtl/wic_wdog.sv
module wic_wdog #(
    parameter int DIV_TICKS = 1024,
    parameter int LOAD_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_en,
    input  logic [LOAD_W-1:0] load_val,
    output logic              expire
);
    localparam int PW = $clog2(DIV_TICKS);

    typedef struct packed {
        logic [PW-1:0]     presc;
        logic [LOAD_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load_en) begin
            st_d.presc = '0;
            st_d.cnt   = load_val;
        end else if (tick && st_q.cnt != '0) begin
            if (st_q.presc == PW'(DIV_TICKS - 1)) begin
                st_d.presc = '0;
                st_d.cnt   = st_q.cnt - 1'b1;
                expire     = (st_q.cnt == LOAD_W'(1));
            end else begin
                st_d.presc = st_q.presc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a stopped counter stays stopped until reloaded
    a_r3_zero_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !load_en) |=> st_q.cnt == '0);
    // R2: without a load the count never rises
    a_r2_no_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> st_q.cnt <= $past(st_q.cnt));
endmodule

// File: rtl/wic_flags.sv
module wic_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic         clr,
    output logic [N-1:0] evt,
    output logic [N-1:0] flags_nxt,
    output logic [N-1:0] flags
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] flg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        evt       = src & ~st_q.prev;
        st_d.prev = src;
        st_d.flg  = (clr ? '0 : st_q.flg) | evt;
        flags_nxt = st_d.flg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flg;

    // R11: an event is never lost, even on a clearing read
    a_r11_set_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));
    // R10: a read without a new event leaves all flags clear
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt == '0) |=> flags == '0);
endmodule

// File: rtl/wic_irq.sv
module wic_irq #(
    parameter int N         = 3,
    parameter int PULSE_CYC = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         gate,
    input  logic [N-1:0] en,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] flags_nxt,
    input  logic         clr,
    input  logic         pulse_mode,
    input  logic         pol_high,
    output logic         irq_o
);
    localparam int PCW = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic [PCW-1:0] pc;
        logic           act;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!gate)                 st_d.pc = '0;
        else if ((evt & en) != '0) st_d.pc = PCW'(PULSE_CYC);
        else if (clr)              st_d.pc = '0;
        else if (st_q.pc != '0)    st_d.pc = st_q.pc - 1'b1;
        if (pulse_mode) st_d.act = (st_d.pc != '0);
        else            st_d.act = gate && ((flags_nxt & en) != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = pol_high ? st_q.act : ~st_q.act;

    // R12: nothing drives the pin while gated
    a_r12_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> !st_q.act);
    // R8: a pulse never exceeds its length
    a_r8_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pc <= PCW'(PULSE_CYC));
    // R7: in level mode an unread enabled flag holds the pin while gated on
    a_r7_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && gate && (flags_nxt & en) != '0) |=> st_q.act);
endmodule

// File: rtl/wic_top.sv
module wic_top #(
    parameter int DIV_TICKS = 1024,
    parameter int LOAD_W    = 6,
    parameter int PULSE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_32k,
    input  logic       pf_in,
    input  logic       alarm_in,
    input  logic       on_main_power,
    input  logic       recall_done,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_out
);
    import wic_pkg::*;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [LOAD_W-1:0] load;
    } st_t;

    st_t st_d, st_q;
    logic load_en, clr, wd_exp, gate;
    logic [NSRC-1:0] evt, flags_nxt, flags, en;
    logic wdata_unused;

    assign wdata_unused = ^reg_wdata[7:LOAD_W];

    always_comb begin
        st_d    = st_q;
        load_en = reg_wr && reg_addr == ADDR_LOAD;
        clr     = reg_rd && reg_addr == ADDR_FLAG;
        if (reg_wr && reg_addr == ADDR_CTRL) st_d.ctrl = ctrl_t'(reg_wdata[4:0]);
        if (load_en) st_d.load = reg_wdata[LOAD_W-1:0];
        case (reg_addr)
            ADDR_CTRL: reg_rdata = 8'(st_q.ctrl);
            ADDR_LOAD: reg_rdata = 8'(st_q.load);
            ADDR_FLAG: reg_rdata = 8'(flags);
            default:   reg_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate = on_main_power && recall_done;
    assign en   = {st_q.ctrl.al_en, st_q.ctrl.pf_en, st_q.ctrl.wd_en};

    wic_wdog #(.DIV_TICKS(DIV_TICKS), .LOAD_W(LOAD_W)) u_wdog (
        .clk(clk), .rst_n(rst_n), .tick(tick_32k), .load_en(load_en),
        .load_val(reg_wdata[LOAD_W-1:0]), .expire(wd_exp)
    );

    wic_flags #(.N(NSRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .src({alarm_in, pf_in, wd_exp}), .clr(clr),
        .evt(evt), .flags_nxt(flags_nxt), .flags(flags)
    );

    wic_irq #(.N(NSRC), .PULSE_CYC(PULSE_CYC)) u_irq (
        .clk(clk), .rst_n(rst_n), .gate(gate), .en(en), .evt(evt),
        .flags_nxt(flags_nxt), .clr(clr), .pulse_mode(st_q.ctrl.pulse),
        .pol_high(st_q.ctrl.pol_high), .irq_o(irq_out)
    );

    // R2: watchdog expiry always lands in flag bit 0
    a_r2_expire_flags: assert property (@(posedge clk) disable iff (!rst_n)
        wd_exp |=> flags[0]);
endmodule

// File: tb/wic_top_tb.sv
module wic_top_tb;
    localparam int P = 4;
    logic clk = 1'b0, rst_n = 1'b0;
    logic tick_32k = 1'b1, pf_in = 1'b0, alarm_in = 1'b0;
    logic on_main_power = 1'b1, recall_done = 1'b1;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic irq_out;
    int n_chk = 0, n_bad = 0;

    logic [2:0] m_flags, m_prev;
    logic [4:0] m_ctrl;
    int m_pc;
    logic m_act;

    always #4 clk = ~clk;

    wic_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .pf_in(pf_in),
        .alarm_in(alarm_in), .on_main_power(on_main_power), .recall_done(recall_done),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cycle();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #2 d = reg_rdata;
        cycle();
        reg_rd = 1'b0;
    endtask

    function automatic logic exp_pin(input logic [4:0] c, input logic act);
        return c[4] ? act : ~act;
    endfunction

    // bench model of flags and pin, one clock edge
    task automatic model_step();
        logic [2:0] set, nf, en;
        logic clr, gate;
        set  = {alarm_in & ~m_prev[2], pf_in & ~m_prev[1], 1'b0};
        clr  = reg_rd && reg_addr == 2'd2;
        gate = on_main_power && recall_done;
        en   = m_ctrl[2:0];
        nf   = (clr ? 3'b000 : m_flags) | set;
        if (!gate)               m_pc = 0;
        else if ((set & en) != 0) m_pc = P;
        else if (clr)            m_pc = 0;
        else if (m_pc != 0)      m_pc--;
        m_act = m_ctrl[3] ? (m_pc != 0) : (gate && (nf & en) != 0);
        if (reg_wr && reg_addr == 2'd0) m_ctrl = reg_wdata[4:0];
        m_prev  = {alarm_in, pf_in, 1'b0};
        m_flags = nf;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) cycle();
        chk(irq_out === 1'b1, "R1 idle pin", irq_out, 1);
        rst_n = 1'b1;
        cycle();
        chk(irq_out === 1'b1, "R1 idle pin after release", irq_out, 1);
        rd(2'd0, d); chk(d == 8'h00, "R1 ctrl reset", d, 0);
        rd(2'd2, d); chk(d == 8'h00, "R1 flags reset", d, 0);

        // R2 timeout of 2 counts, level, active high, watchdog enabled
        wr(2'd0, 8'h11);
        wr(2'd1, 8'h02);
        repeat (2047) cycle();
        chk(irq_out === 1'b0, "R2 before expiry", irq_out, 0);
        cycle();
        chk(irq_out === 1'b1, "R2 at expiry", irq_out, 1);
        repeat (5) cycle();
        chk(irq_out === 1'b1, "R7 level held", irq_out, 1);
        rd(2'd2, d); chk(d == 8'h01, "R2 flag bit0", d, 1);
        chk(irq_out === 1'b0, "R10 pin cleared by read", irq_out, 0);
        rd(2'd2, d); chk(d == 8'h00, "R10 flags cleared", d, 0);

        // R4 reload mid-count
        wr(2'd1, 8'h02);
        repeat (1500) cycle();
        wr(2'd1, 8'h02);
        repeat (2047) cycle();
        chk(irq_out === 1'b0, "R4 old deadline discarded", irq_out, 0);
        cycle();
        chk(irq_out === 1'b1, "R4 new deadline", irq_out, 1);
        rd(2'd2, d);

        // R3 timeout 0 stops the watchdog
        wr(2'd1, 8'h00);
        repeat (3000) cycle();
        chk(irq_out === 1'b0, "R3 no expiry pin", irq_out, 0);
        rd(2'd2, d); chk(d == 8'h00, "R3 no expiry flag", d, 0);

        // R8 pulse mode, power-fail enabled
        wr(2'd0, 8'h1A);
        pf_in = 1'b1;
        for (int i = 0; i < P; i++) begin
            cycle();
            chk(irq_out === 1'b1, "R8 pulse active", irq_out, 1);
        end
        cycle();
        chk(irq_out === 1'b0, "R8 pulse ended", irq_out, 0);
        repeat (4) cycle();
        chk(irq_out === 1'b0, "R5 held level no retrigger", irq_out, 0);
        rd(2'd2, d); chk(d == 8'h02, "R5 pf flag bit1", d, 2);
        pf_in = 1'b0; cycle();

        // R11 event during read, level mode
        wr(2'd0, 8'h12);
        pf_in = 1'b1; reg_rd = 1'b1; reg_addr = 2'd2;
        cycle();
        reg_rd = 1'b0;
        chk(irq_out === 1'b1, "R11 pin on set during read", irq_out, 1);
        rd(2'd2, d); chk(d == 8'h02, "R11 flag kept", d, 2);
        pf_in = 1'b0; cycle();

        // R9 active-low polarity
        wr(2'd0, 8'h02);
        chk(irq_out === 1'b1, "R9 low-active idle", irq_out, 1);
        pf_in = 1'b1; cycle();
        chk(irq_out === 1'b0, "R9 low-active asserted", irq_out, 0);
        rd(2'd2, d); pf_in = 1'b0; cycle();

        // R12 gating with a pending alarm
        wr(2'd0, 8'h14);
        on_main_power = 1'b0;
        alarm_in = 1'b1; repeat (3) cycle();
        chk(irq_out === 1'b0, "R12 gated by backup power", irq_out, 0);
        on_main_power = 1'b1; cycle();
        chk(irq_out === 1'b1, "R12 pending after gate", irq_out, 1);
        rd(2'd2, d); chk(d == 8'h04, "R12 alarm flag bit2", d, 4);
        alarm_in = 1'b0; cycle();

        // R6 disabled source stays readable
        wr(2'd0, 8'h11);
        alarm_in = 1'b1; repeat (2) cycle();
        chk(irq_out === 1'b0, "R6 masked alarm", irq_out, 0);
        rd(2'd2, d); chk(d == 8'h04, "R6 masked flag readable", d, 4);
        alarm_in = 1'b0;

        // random phase with bench model
        wr(2'd0, 8'h00);
        rd(2'd2, d);
        repeat (6) cycle();
        m_flags = 3'b000; m_prev = 3'b000; m_ctrl = 5'h00; m_pc = 0; m_act = 1'b0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] exp_rd;
            tick_32k      = $urandom_range(0, 1) == 1;
            on_main_power = $urandom_range(0, 15) != 0;
            recall_done   = $urandom_range(0, 23) != 0;
            if ($urandom_range(0, 3) == 0) pf_in = ~pf_in;
            if ($urandom_range(0, 3) == 0) alarm_in = ~alarm_in;
            reg_rd    = $urandom_range(0, 5) == 0;
            reg_wr    = $urandom_range(0, 19) == 0;
            reg_addr  = reg_wr ? 2'd0 : 2'(($urandom_range(0, 3) == 1) ? 2 : $urandom_range(0, 3));
            reg_wdata = 8'($urandom_range(0, 31));
            #2;
            if (reg_rd && reg_addr == 2'd2) begin
                exp_rd = {5'b0, m_flags};
                chk(reg_rdata == exp_rd, "R10 random flag read", reg_rdata, exp_rd);
            end
            model_step();
            cycle();
            chk(irq_out === exp_pin(m_ctrl, m_act), "R12 R8 R6 random pin",
                irq_out, exp_pin(m_ctrl, m_act));
        end
        reg_rd = 1'b0; reg_wr = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule